// File: doc/BRIEF.md
# Input Oscillator Frequency Watchdog

This block watches an external input clock (`osc_clk`) against a 1 MHz auxiliary reference clock (`ref_clk`). A free-running edge counter in the input-clock domain is gray coded and carried into the reference domain through a synchroniser. Each reference period is one measurement window, and the block counts the rising edges of the input clock that fall inside it. That count is compared with a programmable lower limit, with a separately enabled upper "bad frequency" limit, and with a harmonic threshold set at twice the upper limit.

A single control register in the reference domain holds the limits, the check enables, a clock-not-good enable, a fault enable, a pin disable and a lock bit. A failing check sets one of three latched flags. The flags drive the fault output and the external fault pin. A separate clock-not-good output shows the result of the latest window only and is not latched. Software clears the flags with a write-one-to-clear pulse. Once the lock bit is set, writes to the control register are ignored until the next reset.

Top module: `osc_freq_watchdog`

## Requirements
- R1: Each reference period measures the number of rising `osc_clk` edges in that period. If the count is below `lo_lim`, flag bit 0 is set. A stopped input clock counts 0. `lo_lim` = 0 never trips this check.
- R2: If `hi_en` is 1 and the count is greater than `hi_lim`, flag bit 1 is set.
- R3: If `harm_en` is 1 and the count is at or above 2·`hi_lim`, flag bit 2 is set.
- R4: Flags stay set until a 1 on the matching bit of `clr` or a reset. When a bit is set and cleared in the same cycle, the set wins.
- R5: `clk_not_good` is 1 when `cng_en` is 1 and any enabled check failed in the latest window. It is not latched.
- R6: `fault` is `fault_en` AND (any flag set). `fault_pin` is `fault` AND NOT `pin_off`.
- R7: A `wr_en` pulse loads `wr_data` into the control register unless the lock bit is already 1. The lock is released only by reset. The reset value is 0. Bit layout:
  - bit 0: `fault_en`
  - bit 1: `pin_off`
  - bit 2: `cng_en`
  - bit 3: `hi_en`
  - bit 4: `harm_en`
  - bit 5: lock
  - bits 11:6: `lo_lim`
  - bits 17:12: `hi_lim`
- R8: No check fires during the first WARMUP (4) reference cycles after reset, so no flag can be set before the fifth cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 1 MHz auxiliary reference clock; one period is one window |
| osc_clk | input | 1 | Monitored input clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 18 | Control register write value |
| clr | input | 3 | Write-one-to-clear mask for the flags |
| ctrl_q | output | 18 | Current control register contents |
| flags | output | 3 | Latched flags: bit 0 low, bit 1 high, bit 2 harmonic |
| clk_not_good | output | 1 | Live clock-not-good status |
| fault | output | 1 | Fault output |
| fault_pin | output | 1 | External fault pin drive |

## Verification
The bench uses the default build:
- 6-bit limits and an 8-bit edge counter.
- Two synchroniser stages and a warm-up of four windows.

The reference period is 192 time units. Input half periods are whole divisors of 96, so the input clock runs at an exact integer multiple N of the reference and its edges never coincide with reference edges. Each window then holds exactly N edges.

N is swept across every such ratio from 1 to 48 under three configurations. The expected flags and outputs are computed arithmetically from N and the limits. This reaches both sides of every comparison, the harmonic boundary, a stopped clock, and both states of every enable.

// File: rtl/osc_wd_pkg.sv
package osc_wd_pkg;
  parameter int LIM_W = 6;
  localparam int CNT_W  = LIM_W + 2;
  localparam int CTRL_W = 6 + 2 * LIM_W;
  localparam int NFLAG  = 3;

  typedef struct packed {
    logic [LIM_W-1:0] hi_lim;
    logic [LIM_W-1:0] lo_lim;
    logic             lock;
    logic             harm_en;
    logic             hi_en;
    logic             cng_en;
    logic             pin_off;
    logic             fault_en;
  } wd_ctrl_t;

  function automatic logic [CNT_W-1:0] bin2gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [CNT_W-1:0] window_delta(input logic [CNT_W-1:0] now,
                                                   input logic [CNT_W-1:0] prev);
    return now - prev;
  endfunction

  function automatic logic below_lo(input logic [CNT_W-1:0] cnt, input logic [LIM_W-1:0] lo);
    return cnt < {2'b00, lo};
  endfunction

  function automatic logic above_hi(input logic [CNT_W-1:0] cnt, input logic [LIM_W-1:0] hi);
    return cnt > {2'b00, hi};
  endfunction

  function automatic logic harmonic(input logic [CNT_W-1:0] cnt, input logic [LIM_W-1:0] hi);
    return cnt >= {1'b0, hi, 1'b0};
  endfunction
endpackage

// File: rtl/osc_edge_counter.sv
module osc_edge_counter
  import osc_wd_pkg::*;
(
  input  logic             osc_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_q
);
  logic [CNT_W-1:0] bin_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_q + 1'b1;
      gray_q <= bin2gray(bin_q + 1'b1);
    end
  end
endmodule

// File: rtl/osc_gray_sync.sv
module osc_gray_sync
  import osc_wd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_in,
  output logic [CNT_W-1:0] count_bin
);
  logic [CNT_W-1:0] stage_q [STAGES];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= gray_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign count_bin = gray2bin(stage_q[STAGES-1]);
endmodule

// File: rtl/osc_window_meter.sv
module osc_window_meter
  import osc_wd_pkg::*;
#(
  parameter int WARMUP = 4
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_bin,
  input  wd_ctrl_t         ctrl,
  output logic             armed,
  output logic [NFLAG-1:0] ev_vec
);
  localparam int WARM_W = $clog2(WARMUP + 1);

  logic [CNT_W-1:0]  prev_q;
  logic [CNT_W-1:0]  meas_q;
  logic [WARM_W-1:0] warm_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      meas_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= count_bin;
      meas_q <= window_delta(count_bin, prev_q);
      if (!armed) warm_q <= warm_q + 1'b1;
    end
  end

  assign armed     = (warm_q == WARM_W'(WARMUP));
  assign ev_vec[0] = armed & below_lo(meas_q, ctrl.lo_lim);
  assign ev_vec[1] = armed & ctrl.hi_en & above_hi(meas_q, ctrl.hi_lim);
  assign ev_vec[2] = armed & ctrl.harm_en & harmonic(meas_q, ctrl.hi_lim);
endmodule

// File: rtl/osc_wd_ctrl_reg.sv
module osc_wd_ctrl_reg
  import osc_wd_pkg::*;
(
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output wd_ctrl_t          ctrl
);
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                    ctrl <= '0;
    else if (wr_en && !ctrl.lock)  ctrl <= wd_ctrl_t'(wr_data);
  end
endmodule

// File: rtl/osc_freq_watchdog.sv
module osc_freq_watchdog
  import osc_wd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WARMUP      = 4
) (
  input  logic              ref_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [NFLAG-1:0]  clr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NFLAG-1:0]  flags,
  output logic              clk_not_good,
  output logic              fault,
  output logic              fault_pin
);
  wd_ctrl_t         ctrl;
  logic [CNT_W-1:0] gray_osc;
  logic [CNT_W-1:0] count_bin;
  logic [NFLAG-1:0] ev_vec;
  logic             armed;
  logic             any_ev;
  logic [NFLAG-1:0] flags_q;
  logic             cng_q;

  osc_edge_counter u_cnt (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .gray_q  (gray_osc)
  );

  osc_gray_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .gray_in   (gray_osc),
    .count_bin (count_bin)
  );

  osc_wd_ctrl_reg u_reg (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  osc_window_meter #(.WARMUP(WARMUP)) u_meter (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .count_bin (count_bin),
    .ctrl      (ctrl),
    .armed     (armed),
    .ev_vec    (ev_vec)
  );

  assign any_ev = |ev_vec;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cng_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr) | ev_vec;
      cng_q   <= ctrl.cng_en & any_ev;
    end
  end

  assign ctrl_q       = ctrl;
  assign flags        = flags_q;
  assign clk_not_good = cng_q;
  assign fault        = ctrl.fault_en & (|flags_q);
  assign fault_pin    = fault & ~ctrl.pin_off;
endmodule

// File: rtl/osc_freq_watchdog_chk.sv
module osc_freq_watchdog_chk
  import osc_wd_pkg::*;
(
  input logic              ref_clk,
  input logic              rst_n,
  input logic [NFLAG-1:0]  clr,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [NFLAG-1:0]  flags,
  input logic              fault,
  input logic              fault_pin,
  input logic              clk_not_good,
  input logic              armed,
  input logic              any_ev
);
  wd_ctrl_t c;
  assign c = wd_ctrl_t'(ctrl_q);

  assert_pin_needs_fault_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fault_pin |-> fault);

  assert_pin_quiet_unarmed_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !c.fault_en |-> !fault_pin);

  assert_lock_freezes_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    c.lock |=> $stable(ctrl_q));

  assert_cng_enabled_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_not_good |-> $past(c.cng_en));

  assert_quiet_warmup_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !armed |-> !any_ev);

  for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
    assert_flag_sticky_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
  end
endmodule

bind osc_freq_watchdog osc_freq_watchdog_chk u_chk (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .ctrl_q       (ctrl_q),
  .flags        (flags),
  .fault        (fault),
  .fault_pin    (fault_pin),
  .clk_not_good (clk_not_good),
  .armed        (armed),
  .any_ev       (any_ev)
);

// File: tb/osc_freq_watchdog_test.sv
module osc_freq_watchdog_test;
  import osc_wd_pkg::*;

  localparam int REF_PERIOD = 192;
  localparam int HALF_UNIT  = REF_PERIOD / 2;

  logic              ref_clk = 1'b0;
  logic              osc_clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [CTRL_W-1:0] wr_data;
  logic [NFLAG-1:0]  clr;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  flags;
  logic              clk_not_good, fault, fault_pin;

  int checks = 0;
  int errors = 0;
  int osc_half = HALF_UNIT / 2;
  bit osc_run = 1'b1;

  osc_freq_watchdog uut (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .clr(clr),
    .ctrl_q(ctrl_q), .flags(flags), .clk_not_good(clk_not_good),
    .fault(fault), .fault_pin(fault_pin)
  );

  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  initial begin
    #1;
    forever begin
      #(osc_half);
      if (osc_run) osc_clk = ~osc_clk;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic write_ctrl(input wd_ctrl_t v);
    @(negedge ref_clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge ref_clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags(input logic [NFLAG-1:0] m);
    @(negedge ref_clk);
    clr = m;
    @(negedge ref_clk);
    clr = '0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  function automatic wd_ctrl_t mk(input int lo, input int hi, input bit hien, input bit harmen,
                                  input bit cng, input bit fen, input bit poff, input bit lk);
    wd_ctrl_t v;
    v = '0;
    v.lo_lim = LIM_W'(lo); v.hi_lim = LIM_W'(hi);
    v.hi_en = hien; v.harm_en = harmen; v.cng_en = cng;
    v.fault_en = fen; v.pin_off = poff; v.lock = lk;
    return v;
  endfunction

  task automatic check_point(input int n, input int lo, input int hi, input bit hien,
                             input bit harmen, input bit cng, input bit fen, input bit poff);
    bit elo, ehi, eharm, eany, efault;
    elo   = n < lo;
    ehi   = hien && (n > hi);
    eharm = harmen && (n >= 2 * hi);
    eany  = elo | ehi | eharm;
    efault = fen && eany;
    check($sformatf("R1 low flag N=%0d lo=%0d", n, lo), int'(flags[0]), int'(elo));
    check($sformatf("R2 high flag N=%0d hi=%0d", n, hi), int'(flags[1]), int'(ehi));
    check($sformatf("R3 harmonic flag N=%0d hi=%0d", n, hi), int'(flags[2]), int'(eharm));
    check($sformatf("R5 clk_not_good N=%0d", n), int'(clk_not_good), int'(cng && eany));
    check($sformatf("R6 fault N=%0d", n), int'(fault), int'(efault));
    check($sformatf("R6 fault_pin N=%0d", n), int'(fault_pin), int'(efault && !poff));
  endtask

  task automatic do_reset();
    @(negedge ref_clk);
    rst_n = 1'b0;
    wait_cycles(2);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge ref_clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    int ns[11] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32, 48};
    wd_ctrl_t x, y, z;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; clr = '0;
    osc_half = HALF_UNIT / 4;
    wait_cycles(3);
    rst_n = 1'b1;
    check("R7 reset ctrl value", int'(ctrl_q), 0);
    check("R4 reset flags", int'(flags), 0);
    check("R5 reset clk_not_good", int'(clk_not_good), 0);
    check("R6 reset fault", int'(fault), 0);
    check("R6 reset fault_pin", int'(fault_pin), 0);

    // R8: low limit at max right after reset; no flag during warm-up
    wr_en = 1'b1; wr_data = mk(63, 0, 0, 0, 0, 0, 0, 0);
    @(negedge ref_clk);
    wr_en = 1'b0;
    wait_cycles(2);
    check("R8 no flag during warm-up", int'(flags), 0);
    wait_cycles(8);
    check("R8 flag after warm-up", int'(flags[0]), 1);

    // Sweep of ratios under three configurations (R1 R2 R3 R5 R6)
    foreach (ns[k]) begin
      osc_half = HALF_UNIT / ns[k];
      for (int c = 0; c < 3; c++) begin
        int lo, hi; bit hien, harmen, cng, fen, poff;
        case (c)
          0: begin lo = 8; hi = 20; hien = 1; harmen = 0; cng = 1; fen = 1; poff = 0; end
          1: begin lo = 3; hi = 5;  hien = 0; harmen = 1; cng = 0; fen = 1; poff = 1; end
          default: begin lo = 0; hi = 12; hien = 1; harmen = 1; cng = 1; fen = 0; poff = 0; end
        endcase
        write_ctrl(mk(lo, hi, hien, harmen, cng, fen, poff, 0));
        wait_cycles(8);
        clear_flags('1);
        wait_cycles(3);
        check_point(ns[k], lo, hi, hien, harmen, cng, fen, poff);
      end
    end

    // R1: stopped input clock counts zero
    write_ctrl(mk(8, 20, 1, 0, 1, 1, 0, 0));
    osc_run = 1'b0;
    wait_cycles(8);
    clear_flags('1);
    wait_cycles(3);
    check_point(0, 8, 20, 1, 0, 1, 1, 0);
    osc_run = 1'b1;

    // R4: set wins over clear; flags sticky after condition ends
    osc_half = HALF_UNIT;
    write_ctrl(mk(10, 0, 0, 0, 0, 1, 0, 0));
    wait_cycles(8);
    check("R4 low flag active N=1", int'(flags[0]), 1);
    clear_flags(3'b001);
    wait_cycles(1);
    check("R4 set wins over clear", int'(flags[0]), 1);
    osc_half = HALF_UNIT / 48;
    wait_cycles(10);
    check("R4 flag sticky after recovery", int'(flags[0]), 1);
    check("R6 fault while sticky", int'(fault), 1);
    clear_flags(3'b001);
    wait_cycles(1);
    check("R4 flag cleared by clr", int'(flags[0]), 0);
    check("R6 fault after clear", int'(fault), 0);

    // R7: lock blocks writes until reset
    x = mk(5, 33, 1, 0, 0, 0, 0, 1);
    y = mk(9, 2, 0, 1, 1, 1, 1, 0);
    z = mk(7, 40, 0, 0, 1, 0, 0, 0);
    write_ctrl(x);
    check("R7 locked write loads", int'(ctrl_q), int'(x));
    write_ctrl(y);
    check("R7 write ignored while locked", int'(ctrl_q), int'(x));
    do_reset();
    check("R7 reset releases lock", int'(ctrl_q), 0);
    write_ctrl(z);
    check("R7 write after reset", int'(ctrl_q), int'(z));

    finish_run();
  end
endmodule